// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides when a small 8-bit microcontroller core sleeps and when it wakes. Software writes a two-bit mode request. A light sleep stops only the processor clock and leaves the peripherals running. A deep sleep stops every clock. While the core sleeps, the block holds the address-latch strobe and the program-fetch strobe at fixed levels: both high in light sleep and both low in deep sleep.

Any pending interrupt ends light sleep. Deep sleep ends only on an external interrupt pin that is enabled, configured as level-triggered, and held low for a programmable number of consecutive oscillator cycles. In either case the block raises a one-cycle wake pulse toward interrupt entry and clears the mode bits in the same cycle. It never touches the saved program counter. An asynchronous reset returns the block to the running state from any mode.

The clock enables come from registers and only change on a clock edge. Each enable then passes through a latch-based clock gate, so neither gated clock can glitch.

Top module: `pmcTop`

## Requirements
- R1: After reset, cpuClkEn=1, perClkEn=1, strobeForce=0, strobeLevel=0 and wakePulse=0.
- R2: In the running state, a write whose data has bit0=1 and bit1=0 enters light sleep. The outputs change on the clock edge that samples the write, to cpuClkEn=0, perClkEn=1, strobeForce=1, strobeLevel=1. A write with both bits 0 changes nothing.
- R3: In the running state, a write with bit1=1 enters deep sleep, with cpuClkEn=0, perClkEn=0, strobeForce=1, strobeLevel=0.
- R4: When bit0 and bit1 are written as 1 together, deep sleep wins.
- R5: In light sleep, any set bit of intPending raises wakePulse and restores cpuClkEn=1 and perClkEn=1 on the next clock edge.
- R6: In deep sleep, only an external pin with extIntEn=1 and extIntEdge=0 (0 = level-triggered, 1 = edge-triggered) held low can wake the block. intPending, edge-configured pins and disabled pins have no effect.
- R7: From deep sleep, wakePulse rises after the edge on which a qualifying pin has been sampled low for HOLD_CYCLES consecutive edges. If the pin returns high earlier, the block stays asleep and the count restarts from zero.
- R8: wakePulse lasts exactly one cycle.
- R9: Writes made while in either sleep mode are ignored.
- R10: Asserting reset during either sleep mode returns the block to the R1 state.
- R11: cpuClk stays low whenever cpuClkEn is 0, and perClk stays low whenever perClkEn is 0. When an enable is 1, the gated clock follows clk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| wrEn | input | 1 | Mode register write strobe |
| wrData | input | 2 | Write data: bit0 light sleep, bit1 deep sleep |
| intPending | input | NUM_INT | Pending enabled interrupt flags |
| extIntN | input | NUM_EXT | External interrupt pins, active low |
| extIntEn | input | NUM_EXT | Per-pin enable |
| extIntEdge | input | NUM_EXT | Per-pin trigger type: 1 edge, 0 level |
| cpuClkEn | output | 1 | Processor clock enable |
| perClkEn | output | 1 | Peripheral clock enable |
| cpuClk | output | 1 | Gated processor clock |
| perClk | output | 1 | Gated peripheral clock |
| strobeForce | output | 1 | Strobes are overridden by this block |
| strobeLevel | output | 1 | Level driven on both strobes when overridden |
| wakePulse | output | 1 | One-cycle wake request to interrupt entry |

## Verification
The bench builds the block with HOLD_CYCLES=16, NUM_INT=4 and NUM_EXT=2. With a 16-cycle hold, every short low pulse from 1 to 15 cycles can be tried, and each full-hold wake can be timed to the exact edge. With two pins, all four enable and trigger-type combinations can be swept on each pin. The bench also sweeps all four write values and wakes light sleep from each of the four interrupt flags.

// File: rtl/pmcPkg.sv
package pmcPkg;
  // Strobes from the decision logic to the state holder
  typedef struct packed {
    logic setIdle;
    logic setPd;
    logic clrModes;
    logic cntInc;
    logic cntClr;
    logic wake;
  } pmcStrb_t;
endpackage

// File: rtl/pmcCtrl.sv
module pmcCtrl
  import pmcPkg::*;
#(
  parameter int NUM_INT = 8,
  parameter int NUM_EXT = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [1:0]         wrData,
  input  logic [NUM_INT-1:0] intPending,
  input  logic [NUM_EXT-1:0] extIntN,
  input  logic [NUM_EXT-1:0] extIntEn,
  input  logic [NUM_EXT-1:0] extIntEdge,
  input  logic               modeIdle,
  input  logic               modePd,
  input  logic               cntDone,
  output pmcStrb_t           strb
);
  logic running;
  logic levelReq;
  logic wakeIdle;
  logic wakePd;

  assign running  = !modeIdle && !modePd;
  assign levelReq = |(extIntEn & ~extIntEdge & ~extIntN);
  assign wakeIdle = modeIdle && (|intPending);
  assign wakePd   = modePd && levelReq && cntDone;

  always_comb begin
    strb          = '0;
    strb.setPd    = running && wrEn && wrData[1];
    strb.setIdle  = running && wrEn && wrData[0] && !wrData[1];
    strb.wake     = wakeIdle || wakePd;
    strb.clrModes = wakeIdle || wakePd;
    strb.cntInc   = modePd && levelReq && !cntDone;
    strb.cntClr   = !(modePd && levelReq) || cntDone;
  end

  AST_PD_LEVEL_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (modePd && !levelReq) |-> !strb.wake); // R6

  AST_RUN_NO_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    (!modeIdle && !modePd) |-> !strb.wake); // R9
endmodule

// File: rtl/pmcDatapath.sv
module pmcDatapath
  import pmcPkg::*;
#(
  parameter int HOLD_CYCLES = 1024,
  localparam int CW = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1
) (
  input  logic     clk,
  input  logic     rstN,
  input  pmcStrb_t strb,
  output logic     modeIdle,
  output logic     modePd,
  output logic     cntDone,
  output logic     wakePulse
);
  logic [CW-1:0] holdCnt;

  assign cntDone = (holdCnt == CW'(HOLD_CYCLES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeIdle  <= 1'b0;
      modePd    <= 1'b0;
      holdCnt   <= '0;
      wakePulse <= 1'b0;
    end else begin
      wakePulse <= strb.wake;
      if (strb.clrModes) begin
        modeIdle <= 1'b0;
        modePd   <= 1'b0;
      end else if (strb.setPd) begin
        modePd <= 1'b1;
      end else if (strb.setIdle) begin
        modeIdle <= 1'b1;
      end
      if (strb.cntClr)      holdCnt <= '0;
      else if (strb.cntInc) holdCnt <= holdCnt + 1'b1;
    end
  end

  AST_HOLD_BEFORE_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    (modePd && strb.wake) |-> cntDone); // R7

  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |=> !wakePulse); // R8

  AST_MODES_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(modeIdle && modePd)); // R4

  AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> (!modeIdle && !modePd)); // R5
endmodule

// File: rtl/pmcClkGate.sv
module pmcClkGate #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic [N-1:0] en,
  output logic [N-1:0] gclk
);
  for (genvar i = 0; i < N; i++) begin : gGate
    logic enLat;
    always_latch begin
      if (!clk) enLat = en[i];
    end
    assign gclk[i] = clk & enLat;
  end
endmodule

// File: rtl/pmcTop.sv
module pmcTop
  import pmcPkg::*;
#(
  parameter int HOLD_CYCLES = 1024,
  parameter int NUM_INT     = 8,
  parameter int NUM_EXT     = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [1:0]         wrData,
  input  logic [NUM_INT-1:0] intPending,
  input  logic [NUM_EXT-1:0] extIntN,
  input  logic [NUM_EXT-1:0] extIntEn,
  input  logic [NUM_EXT-1:0] extIntEdge,
  output logic               cpuClkEn,
  output logic               perClkEn,
  output logic               cpuClk,
  output logic               perClk,
  output logic               strobeForce,
  output logic               strobeLevel,
  output logic               wakePulse
);
  pmcStrb_t strb;
  logic     modeIdle;
  logic     modePd;
  logic     cntDone;
  logic [1:0] gated;

  pmcCtrl #(.NUM_INT(NUM_INT), .NUM_EXT(NUM_EXT)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .intPending(intPending), .extIntN(extIntN), .extIntEn(extIntEn),
    .extIntEdge(extIntEdge), .modeIdle(modeIdle), .modePd(modePd),
    .cntDone(cntDone), .strb(strb)
  );

  pmcDatapath #(.HOLD_CYCLES(HOLD_CYCLES)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .modeIdle(modeIdle),
    .modePd(modePd), .cntDone(cntDone), .wakePulse(wakePulse)
  );

  assign cpuClkEn    = !modeIdle && !modePd;
  assign perClkEn    = !modePd;
  assign strobeForce = modeIdle || modePd;
  assign strobeLevel = modeIdle;

  pmcClkGate #(.N(2)) uGate (
    .clk(clk), .en({perClkEn, cpuClkEn}), .gclk(gated)
  );
  assign cpuClk = gated[0];
  assign perClk = gated[1];

  AST_WAKE_RUNS_CPU: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> (cpuClkEn && perClkEn)); // R5

  AST_SLEEP_STROBES: assert property (@(posedge clk) disable iff (!rstN)
    !cpuClkEn |-> (strobeForce && (strobeLevel == perClkEn))); // R2
endmodule

// File: tb/sim_pmcTop.sv
module sim_pmcTop;
  localparam int HOLD = 16;
  localparam int NI   = 4;
  localparam int NE   = 2;
  localparam logic [3:0] ST_RUN  = 4'b1100;
  localparam logic [3:0] ST_IDLE = 4'b0111;
  localparam logic [3:0] ST_PD   = 4'b0010;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrData = '0;
  logic [NI-1:0] intPending = '0;
  logic [NE-1:0] extIntN = '1;
  logic [NE-1:0] extIntEn = '0;
  logic [NE-1:0] extIntEdge = '0;
  logic cpuClkEn, perClkEn, cpuClk, perClk, strobeForce, strobeLevel, wakePulse;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pmcTop #(.HOLD_CYCLES(HOLD), .NUM_INT(NI), .NUM_EXT(NE)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .intPending(intPending), .extIntN(extIntN), .extIntEn(extIntEn),
    .extIntEdge(extIntEdge), .cpuClkEn(cpuClkEn), .perClkEn(perClkEn),
    .cpuClk(cpuClk), .perClk(perClk), .strobeForce(strobeForce),
    .strobeLevel(strobeLevel), .wakePulse(wakePulse)
  );

  function automatic logic [3:0] st();
    return {cpuClkEn, perClkEn, strobeForce, strobeLevel};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [1:0] v);
    @(negedge clk); wrEn = 1'b1; wrData = v;
    @(negedge clk); wrEn = 1'b0; wrData = '0;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
  endtask

  // hold a qualifying pin low, return edge count at which wake seen (0 = none)
  task automatic holdLow(input int pin, input int len, output int seenAt);
    seenAt = 0;
    extIntN[pin] = 1'b0;
    for (int n = 1; n <= len; n++) begin
      @(negedge clk);
      if (wakePulse && seenAt == 0) seenAt = n;
    end
    extIntN[pin] = 1'b1;
  endtask

  initial begin
    int seen;
    repeat (2) @(negedge clk);
    check(st() == ST_RUN && !wakePulse, "R1", st(), ST_RUN);
    rstN = 1'b1;
    @(negedge clk);
    check(st() == ST_RUN && !wakePulse, "R1", st(), ST_RUN);

    // sweep of write values from running state
    for (int v = 0; v < 4; v++) begin
      logic [3:0] exp;
      doWrite(2'(v));
      exp = v[1] ? ST_PD : (v[0] ? ST_IDLE : ST_RUN);
      if (v == 3) check(st() == exp, "R4", st(), exp);
      else if (v == 2) check(st() == exp, "R3", st(), exp);
      else check(st() == exp, "R2", st(), exp);
      doReset();
      @(negedge clk);
    end

    // gated clocks per mode (R11): sample inside high phase
    @(posedge clk); #5;
    check(cpuClk && perClk, "R11", {cpuClk, perClk}, 2'b11);
    doWrite(2'b01);
    @(posedge clk); #5;
    check(!cpuClk && perClk, "R11", {cpuClk, perClk}, 2'b01);
    // write while idle is ignored (R9)
    doWrite(2'b10);
    check(st() == ST_IDLE, "R9", st(), ST_IDLE);
    doReset();
    check(st() == ST_RUN, "R10", st(), ST_RUN);
    doWrite(2'b10);
    @(posedge clk); #5;
    check(!cpuClk && !perClk, "R11", {cpuClk, perClk}, 2'b00);
    doWrite(2'b01);
    check(st() == ST_PD, "R9", st(), ST_PD);
    doReset();
    check(st() == ST_RUN && !wakePulse, "R10", st(), ST_RUN);

    // idle wake from each interrupt flag
    for (int b = 0; b < NI; b++) begin
      doWrite(2'b01);
      repeat (3) @(negedge clk);
      check(st() == ST_IDLE, "R5", st(), ST_IDLE);
      intPending[b] = 1'b1;
      @(negedge clk);
      check(wakePulse && st() == ST_RUN, "R5", {wakePulse, st()}, {1'b1, ST_RUN});
      intPending = '0;
      @(negedge clk);
      check(!wakePulse, "R8", wakePulse, 0);
    end

    // deep sleep: pin configuration sweep, intPending asserted throughout
    for (int p = 0; p < NE; p++) begin
      for (int cfg = 0; cfg < 4; cfg++) begin
        bit expWake;
        extIntEn = '0; extIntEdge = '0;
        extIntEn[p] = cfg[0]; extIntEdge[p] = cfg[1];
        expWake = cfg[0] && !cfg[1];
        doWrite(2'b10);
        intPending = '1;
        holdLow(p, HOLD + 4, seen);
        intPending = '0;
        if (expWake) begin
          check(seen == HOLD, "R7", seen, HOLD);
          check(st() == ST_RUN, "R6", st(), ST_RUN);
        end else begin
          check(seen == 0 && st() == ST_PD, "R6", seen, 0);
          doReset();
        end
        @(negedge clk);
      end
    end

    // short pulses never wake; count restarts
    extIntEn = 2'b01; extIntEdge = '0;
    doWrite(2'b10);
    for (int len = 1; len < HOLD; len++) begin
      holdLow(0, len, seen);
      @(negedge clk);
      check(seen == 0 && !wakePulse && st() == ST_PD, "R7", seen, 0);
    end
    holdLow(0, HOLD + 2, seen);
    check(seen == HOLD, "R7", seen, HOLD);
    @(negedge clk);
    check(!wakePulse && st() == ST_RUN, "R8", wakePulse, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule